// File: doc/BRIEF.md
# Serial Shift-Chain I/O Controller

This block runs two external shift registers from a host-side command interface. One is a parallel-load register that captures a set of input pins and returns them serially. The other is a serial-load register with a latched parallel output. Both registers share a single shift clock. The controller produces the serial data line, the shift clock, an input-load strobe and an output-latch strobe, and it reads one serial return line.

The host issues either a get or a set, each with a bit count N. A get captures the external inputs and shifts N of them back into a 32-bit result. A set shifts the N low bits of a data word out and then pulses the latch strobe, so the new pattern appears on the external outputs. The length of every pin phase is a fixed number of system clock cycles given by a parameter. A single-cycle done pulse marks the end of each command.

Top module: `shift_chain_io`

## Requirements
- R1: After reset, and in every cycle where busy is low, the pins sit at their idle levels: ser_out low after reset, shift_clk high, load_in low and latch_out high. After reset, busy and done are also low.
- R2: A get with N>0 first drives ser_out low. It then holds load_in high for PHASE_CYCLES cycles and low for PHASE_CYCLES cycles before shift_clk falls for the first time. shift_clk stays high while load_in is high.
- R3: A get takes N samples of ser_in. Each sample is taken on the clock edge where shift_clk is driven low, before that shift occurs. Each sample enters the result at bit 0 while older samples move up one place. Bit 0 therefore holds the last sample and bits N and above are zero. A get shorter than the input chain returns its most significant inputs.
- R4: Each shift holds shift_clk low for PHASE_CYCLES cycles and then high for PHASE_CYCLES cycles. A command with count N produces exactly N falling edges.
- R5: A set sends bits N-1 down to 0 of cmd_data, highest first. ser_out takes each bit PHASE_CYCLES cycles before the matching shift_clk fall and holds it through the following rise.
- R6: After the high phase of the last shift of a set, latch_out goes low once for PHASE_CYCLES cycles and then returns high. It is never low while shift_clk is low or load_in is high.
- R7: A command with an effective count of zero causes no shift_clk, load_in or latch_out activity. busy never rises for it, and done pulses on the accepting edge.
- R8: A command presented while busy is high is ignored. It has no effect on the pins, the latched outputs or the done sequence.
- R9: done is high for exactly one cycle per accepted command, and busy falls on the same edge that raises done.
- R10: When cmd_get and cmd_set are both high, the get is carried out. Any count above MAX_BITS (32) is treated as MAX_BITS.
- R11: From the accepting edge to the edge that raises done, a get takes 2·PHASE_CYCLES·(N+1) cycles and a set takes PHASE_CYCLES·(3N+1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_get | input | 1 | Request a capture-and-read of N input bits |
| cmd_set | input | 1 | Request a write of N output bits |
| cmd_count | input | 6 | Bit count N; values above 32 are clamped |
| cmd_data | input | 32 | Output pattern for a set; bit N-1 is sent first |
| busy | output | 1 | A command is in progress; new commands are ignored |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Bits collected by the most recent get |
| ser_out | output | 1 | Serial data toward the output register |
| shift_clk | output | 1 | Shared shift clock, idles high |
| load_in | output | 1 | Input-capture strobe, idles low, captures on its falling edge |
| latch_out | output | 1 | Output-latch strobe, idles high, pulsed low after a set |
| ser_in | input | 1 | Serial data returned by the input register |

## Verification
The assertions assume that ser_in is a settled, synchronous level at every edge where shift_clk is driven low. The bench meets this by modelling the external input register in step with the system clock. It updates that model only from the pin levels it sees at falling clock edges. The assertions also assume commands are simple level requests sampled at an edge. The bench drives cmd_get, cmd_set and their operands only at falling clock edges. It holds each request for one cycle, except for the deliberate request made while busy, which tests that such requests are ignored.

// File: rtl/sc_pkg.sv
// Shared types for the shift-chain I/O controller.
// Assumes: nothing beyond IEEE 1800-2017 enumerations.
package sc_pkg;

    // Sequencer states; each non-idle state lasts exactly one pin phase.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOAD_HI = 3'd1,
        ST_LOAD_LO = 3'd2,
        ST_SETTLE  = 3'd3,
        ST_CLK_LO  = 3'd4,
        ST_CLK_HI  = 3'd5,
        ST_LATCH   = 3'd6
    } sc_state_e;

endpackage

// File: rtl/sc_phase_timer.sv
// Phase timer: while run is high, raises phase_end on every PHASE_CYCLES-th
// cycle. It restarts from zero whenever run is low.
// Assumes: PHASE_CYCLES >= 1; run rises on the edge a new phase starts.
module sc_phase_timer #(
    parameter int PHASE_CYCLES = 4,
    localparam int CW = (PHASE_CYCLES < 2) ? 1 : $clog2(PHASE_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);

    logic [CW-1:0] cnt_q;

    assign phase_end = run && (cnt_q == CW'(PHASE_CYCLES - 1));

    // Count cycles within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || phase_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sc_datapath.sv
// Data path: keeps the outgoing word left-aligned so the next bit to send is
// always the MSB. It tracks the number of shifts left and accumulates
// returned bits into the result.
// Assumes: n_eff <= MAX_BITS; accept and advance are single-cycle strobes.
module sc_datapath #(
    parameter int MAX_BITS = 32,
    localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                accept_get,
    input  logic [CNT_W-1:0]    n_eff,
    input  logic [MAX_BITS-1:0] cmd_data,
    input  logic                sample_en,
    input  logic                advance,
    input  logic                ser_in,
    output logic                first_bit,
    output logic                cur_bit,
    output logic                rem_zero,
    output logic [MAX_BITS-1:0] result
);

    logic [CNT_W-1:0]    rem_q;
    logic [MAX_BITS-1:0] word_q;
    logic [MAX_BITS-1:0] acc_q;
    logic [CNT_W-1:0]    align_sh;
    logic [MAX_BITS-1:0] aligned;

    // Move bit N-1 of the command word up to the MSB position.
    always_comb begin
        align_sh = CNT_W'(MAX_BITS) - n_eff;
        aligned  = cmd_data << align_sh;
    end

    assign first_bit = aligned[MAX_BITS-1];
    assign cur_bit   = word_q[MAX_BITS-1];
    assign rem_zero  = (rem_q == '0);
    assign result    = acc_q;

    // Remaining-shift counter and outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            word_q <= '0;
        end else if (accept) begin
            rem_q  <= n_eff;
            word_q <= aligned;
        end else if (advance) begin
            rem_q  <= rem_q - 1'b1;
            word_q <= {word_q[MAX_BITS-2:0], 1'b0};
        end
    end

    // Returned-bit accumulator; the newest sample lands in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || accept_get) begin
            acc_q <= '0;
        end else if (sample_en) begin
            acc_q <= {acc_q[MAX_BITS-2:0], ser_in};
        end
    end

endmodule

// File: rtl/sc_sequencer.sv
// Sequencer: orders the load, settle, shift and latch phases, drives the
// four pin outputs from registers and issues strobes to the data path.
// Assumes: phase_end comes from a timer that runs whenever busy is high.
module sc_sequencer
    import sc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_get,
    input  logic cmd_set,
    input  logic n_zero,
    input  logic phase_end,
    input  logic first_bit,
    input  logic cur_bit,
    input  logic rem_zero,
    output logic busy,
    output logic done,
    output logic accept,
    output logic accept_get,
    output logic sample_en,
    output logic advance,
    output logic ser_out,
    output logic shift_clk,
    output logic load_in,
    output logic latch_out
);

    sc_state_e state_q;
    logic      is_get_q;
    logic      ser_q;
    logic      sclk_q;
    logic      load_q;
    logic      latch_q;
    logic      done_q;
    logic      cmd_any;

    assign cmd_any    = cmd_get || cmd_set;
    assign busy       = (state_q != ST_IDLE);
    assign accept     = !busy && cmd_any && !n_zero;
    assign accept_get = accept && cmd_get;
    assign advance    = phase_end && (state_q == ST_CLK_LO);
    assign done       = done_q;
    assign ser_out    = ser_q;
    assign shift_clk  = sclk_q;
    assign load_in    = load_q;
    assign latch_out  = latch_q;

    // Sample on each edge that drives shift_clk low during a get.
    always_comb begin
        sample_en = 1'b0;
        if (phase_end && is_get_q) begin
            if (state_q == ST_LOAD_LO) begin
                sample_en = 1'b1;
            end else if ((state_q == ST_CLK_HI) && !rem_zero) begin
                sample_en = 1'b1;
            end
        end
    end

    // State and pin register updates at phase boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            is_get_q <= 1'b0;
            ser_q    <= 1'b0;
            sclk_q   <= 1'b1;
            load_q   <= 1'b0;
            latch_q  <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_any) begin
                        if (n_zero) begin
                            done_q <= 1'b1;
                        end else if (cmd_get) begin
                            state_q  <= ST_LOAD_HI;
                            is_get_q <= 1'b1;
                            ser_q    <= 1'b0;
                            load_q   <= 1'b1;
                        end else begin
                            state_q  <= ST_SETTLE;
                            is_get_q <= 1'b0;
                            ser_q    <= first_bit;
                        end
                    end
                end
                ST_LOAD_HI: begin
                    if (phase_end) begin
                        state_q <= ST_LOAD_LO;
                        load_q  <= 1'b0;
                    end
                end
                ST_LOAD_LO, ST_SETTLE: begin
                    if (phase_end) begin
                        state_q <= ST_CLK_LO;
                        sclk_q  <= 1'b0;
                    end
                end
                ST_CLK_LO: begin
                    if (phase_end) begin
                        state_q <= ST_CLK_HI;
                        sclk_q  <= 1'b1;
                    end
                end
                ST_CLK_HI: begin
                    if (phase_end) begin
                        if (rem_zero) begin
                            if (is_get_q) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                state_q <= ST_LATCH;
                                latch_q <= 1'b0;
                            end
                        end else if (is_get_q) begin
                            state_q <= ST_CLK_LO;
                            sclk_q  <= 1'b0;
                        end else begin
                            state_q <= ST_SETTLE;
                            ser_q   <= cur_bit;
                        end
                    end
                end
                ST_LATCH: begin
                    if (phase_end) begin
                        state_q <= ST_IDLE;
                        latch_q <= 1'b1;
                        done_q  <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/shift_chain_io.sv
// Top level: clamps the requested count, then connects the phase timer, the
// sequencer and the data path. Every pin output comes from a register.
// Assumes: ser_in is stable and synchronous at the edges that lower
// shift_clk; commands are sampled only while busy is low.
module shift_chain_io #(
    parameter int MAX_BITS     = 32,
    parameter int PHASE_CYCLES = 4,
    localparam int CNT_W = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_get,
    input  logic                cmd_set,
    input  logic [CNT_W-1:0]    cmd_count,
    input  logic [MAX_BITS-1:0] cmd_data,
    output logic                busy,
    output logic                done,
    output logic [MAX_BITS-1:0] result,
    output logic                ser_out,
    output logic                shift_clk,
    output logic                load_in,
    output logic                latch_out,
    input  logic                ser_in
);

    logic [CNT_W-1:0] n_eff;
    logic n_zero;
    logic phase_end;
    logic accept;
    logic accept_get;
    logic sample_en;
    logic advance;
    logic first_bit;
    logic cur_bit;
    logic rem_zero;

    // Clamp the requested count to the supported maximum.
    always_comb begin
        n_eff  = (cmd_count > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : cmd_count;
        n_zero = (n_eff == '0);
    end

    sc_phase_timer #(
        .PHASE_CYCLES(PHASE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .phase_end(phase_end)
    );

    sc_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_get   (cmd_get),
        .cmd_set   (cmd_set),
        .n_zero    (n_zero),
        .phase_end (phase_end),
        .first_bit (first_bit),
        .cur_bit   (cur_bit),
        .rem_zero  (rem_zero),
        .busy      (busy),
        .done      (done),
        .accept    (accept),
        .accept_get(accept_get),
        .sample_en (sample_en),
        .advance   (advance),
        .ser_out   (ser_out),
        .shift_clk (shift_clk),
        .load_in   (load_in),
        .latch_out (latch_out)
    );

    sc_datapath #(
        .MAX_BITS(MAX_BITS)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .accept_get(accept_get),
        .n_eff     (n_eff),
        .cmd_data  (cmd_data),
        .sample_en (sample_en),
        .advance   (advance),
        .ser_in    (ser_in),
        .first_bit (first_bit),
        .cur_bit   (cur_bit),
        .rem_zero  (rem_zero),
        .result    (result)
    );

endmodule

// File: rtl/sc_io_checker.sv
// Protocol checker for the shift-chain I/O pins, bound to shift_chain_io.
// Phase widths are measured with saturating counters, not long $past chains.
module sc_io_checker #(
    parameter int PHASE_CYCLES = 4,
    localparam int LW = $clog2(PHASE_CYCLES + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic ser_out,
    input logic shift_clk,
    input logic load_in,
    input logic latch_out
);

    logic [LW-1:0] clk_low_cnt;
    logic [LW-1:0] latch_low_cnt;

    // Count how long shift_clk and latch_out have been low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_low_cnt   <= '0;
            latch_low_cnt <= '0;
        end else begin
            if (shift_clk) clk_low_cnt <= '0;
            else if (clk_low_cnt != LW'(PHASE_CYCLES + 1)) clk_low_cnt <= clk_low_cnt + 1'b1;
            if (latch_out) latch_low_cnt <= '0;
            else if (latch_low_cnt != LW'(PHASE_CYCLES + 1)) latch_low_cnt <= latch_low_cnt + 1'b1;
        end
    end

    AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (shift_clk && !load_in && latch_out)); // R1
    AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        load_in |-> (shift_clk && !ser_out)); // R2
    AST_CLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk) |-> (clk_low_cnt == LW'(PHASE_CYCLES))); // R4
    AST_DATA_SETTLED_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_clk) |-> $stable(ser_out)); // R5
    AST_DATA_SETTLED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shift_clk) |-> $stable(ser_out)); // R5
    AST_LATCH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_out |-> (shift_clk && !load_in)); // R6
    AST_LATCH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_out) |-> (latch_low_cnt == LW'(PHASE_CYCLES))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9

endmodule

bind shift_chain_io sc_io_checker #(
    .PHASE_CYCLES(PHASE_CYCLES)
) u_sc_io_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .ser_out  (ser_out),
    .shift_clk(shift_clk),
    .load_in  (load_in),
    .latch_out(latch_out)
);

// File: tb/shift_chain_io_bench.sv
module shift_chain_io_bench;
    localparam int MAXB = 32;
    localparam int PH   = 3;
    localparam int INB  = 16;
    localparam int CW   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            cmd_get = 1'b0;
    logic            cmd_set = 1'b0;
    logic [CW-1:0]   cmd_count = '0;
    logic [MAXB-1:0] cmd_data = '0;
    logic            busy, done, ser_out, shift_clk, load_in, latch_out, ser_in;
    logic [MAXB-1:0] result;

    shift_chain_io #(.MAX_BITS(MAXB), .PHASE_CYCLES(PH)) u_shift_chain_io (
        .clk(clk), .rst_n(rst_n), .cmd_get(cmd_get), .cmd_set(cmd_set),
        .cmd_count(cmd_count), .cmd_data(cmd_data), .busy(busy), .done(done),
        .result(result), .ser_out(ser_out), .shift_clk(shift_clk),
        .load_in(load_in), .latch_out(latch_out), .ser_in(ser_in)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // External register models and pin-activity counters, sampled at negedge.
    logic [INB-1:0]  pin_in = 16'hC3A5;
    logic [INB-1:0]  piso = '0;
    logic [MAXB-1:0] sipo = '0;
    logic [MAXB-1:0] latched = '0;
    logic p_load = 1'b0, p_sclk = 1'b1, p_latch = 1'b1;
    int n_falls = 0, n_load = 0, n_latch = 0, load_hi = 0, latch_lo = 0, clk_lo = 0, ser_bad = 0;

    assign ser_in = piso[INB-1];

    always @(negedge clk) begin
        if (p_load && !load_in) piso = pin_in;
        else if (p_sclk && !shift_clk) piso = piso << 1;
        if (!p_sclk && shift_clk) sipo = {sipo[MAXB-2:0], ser_out};
        if (!p_latch && latch_out) latched = sipo;
        if (p_sclk && !shift_clk) n_falls++;
        if (!p_load && load_in) n_load++;
        if (p_latch && !latch_out) n_latch++;
        if (load_in) load_hi++;
        if (!latch_out) latch_lo++;
        if (!shift_clk) clk_lo++;
        if (load_in && ser_out) ser_bad++;
        p_load  = load_in;
        p_sclk  = shift_clk;
        p_latch = latch_out;
    end

    typedef struct {
        bit              is_get;
        int              n;
        logic [MAXB-1:0] data;
        logic [MAXB-1:0] exp_res;
        int              lat;
        int              c0;
        int              falls0, load0, latch0, lhi0, llo0, clo0, bad0;
        logic [MAXB-1:0] latched0;
    } item_t;

    item_t exp_q[$];

    function automatic logic [MAXB-1:0] exp_get(input int n, input logic [INB-1:0] pins);
        logic [MAXB-1:0] w;
        w = {{(MAXB-INB){1'b0}}, pins};
        if (n <= INB) return w >> (INB - n);
        return w << (n - INB);
    endfunction

    // Driver: present one command, push its expectation, wait for the end.
    task automatic issue(input bit g, input bit s, input int cnt, input logic [MAXB-1:0] d, input bit poke);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_get = g; cmd_set = s; cmd_count = CW'(cnt); cmd_data = d;
        @(posedge clk);
        #1;
        it.is_get = g;
        it.n      = (cnt > MAXB) ? MAXB : cnt;
        it.data   = d;
        it.exp_res = exp_get(it.n, pin_in);
        if (it.n == 0) it.lat = 0;
        else if (g) it.lat = 2 * PH * (it.n + 1);
        else it.lat = PH * (3 * it.n + 1);
        it.c0 = cyc;
        it.falls0 = n_falls; it.load0 = n_load; it.latch0 = n_latch;
        it.lhi0 = load_hi; it.llo0 = latch_lo; it.clo0 = clk_lo; it.bad0 = ser_bad;
        it.latched0 = latched;
        exp_q.push_back(it);
        @(negedge clk);
        cmd_get = 1'b0; cmd_set = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            cmd_set = 1'b1; cmd_count = CW'(8); cmd_data = 32'h0000_00FF;
            @(negedge clk);
            cmd_set = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pop the expectation on each done and compare.
    initial begin
        item_t it;
        logic [MAXB-1:0] mask;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(cyc - it.c0 == it.lat, "R11 latency", cyc - it.c0, it.lat);
                    check(n_falls - it.falls0 == it.n, "R4 shift count", n_falls - it.falls0, it.n);
                    check(clk_lo - it.clo0 == it.n * PH, "R4 low phase cycles", clk_lo - it.clo0, it.n * PH);
                    if (it.n == 0) begin
                        check(n_load == it.load0 && n_latch == it.latch0, "R7 no strobes",
                              (n_load - it.load0) + (n_latch - it.latch0), 0);
                        check(latched == it.latched0, "R7 outputs kept", latched, it.latched0);
                    end else if (it.is_get) begin
                        check(result == it.exp_res, "R3 get result", result, it.exp_res);
                        check(n_load - it.load0 == 1, "R2 one load pulse", n_load - it.load0, 1);
                        check(load_hi - it.lhi0 == PH, "R2 load high cycles", load_hi - it.lhi0, PH);
                        check(ser_bad == it.bad0, "R2 ser_out low during load", ser_bad - it.bad0, 0);
                        check(n_latch == it.latch0, "R6 no latch on get", n_latch - it.latch0, 0);
                        check(latched == it.latched0, "R8 outputs unchanged", latched, it.latched0);
                    end else begin
                        mask = (it.n >= MAXB) ? '1 : ((32'h1 << it.n) - 1);
                        check((latched & mask) == (it.data & mask), "R5 set data", latched & mask, it.data & mask);
                        check(n_latch - it.latch0 == 1, "R6 one latch pulse", n_latch - it.latch0, 1);
                        check(latch_lo - it.llo0 == PH, "R6 latch low cycles", latch_lo - it.llo0, PH);
                        check(n_load == it.load0, "R5 no load on set", n_load - it.load0, 0);
                    end
                    @(negedge clk);
                    #1;
                    check(!done, "R9 done one cycle", done, 0);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
        check(shift_clk && !load_in && latch_out && !ser_out, "R1 pin levels after reset",
              {shift_clk, load_in, latch_out, ser_out}, 4'b1010);

        issue(1'b0, 1'b1, 8, 32'h0000_00A5, 1'b0);   // R5 set
        issue(1'b1, 1'b0, 8, '0, 1'b0);              // R3 short get
        issue(1'b1, 1'b0, 16, '0, 1'b0);             // R3 full chain
        pin_in = 16'h5A0F;
        issue(1'b1, 1'b0, 5, '0, 1'b0);              // R3 top bits only
        issue(1'b1, 1'b0, 32, '0, 1'b0);             // R3 longer than chain
        issue(1'b1, 1'b0, 20, '0, 1'b0);
        issue(1'b0, 1'b1, 32, 32'hDEAD_BEEF, 1'b0);  // R5 full word
        issue(1'b0, 1'b1, 1, 32'h0000_0000, 1'b0);   // R5 single bit
        issue(1'b0, 1'b1, 0, 32'hFFFF_FFFF, 1'b0);   // R7 zero set
        issue(1'b1, 1'b0, 0, '0, 1'b0);              // R7 zero get
        pin_in = 16'hF00D;
        issue(1'b1, 1'b0, 6, '0, 1'b1);              // R8 request while busy
        issue(1'b1, 1'b1, 3, 32'h0000_0007, 1'b0);   // R10 get wins
        issue(1'b1, 1'b0, 40, '0, 1'b0);             // R10 count clamp on get
        issue(1'b0, 1'b1, 40, 32'h1234_5678, 1'b0);  // R10 count clamp on set

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R9 every command completed", exp_q.size(), 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule